// File: doc/BRIEF.md
# RGB Line-Spacing Alignment Buffer

This block sits behind the digitisers of a three-row colour line sensor. Each colour row is read out as two half-rate streams, one holding the odd-numbered pixels and one the even-numbered pixels. All six streams arrive together with one shared valid strobe and a class tag. The block keeps only the active picture positions. It puts each odd/even pair back into raster order. It also delays the colour rows that see a given document line early, so that red, green and blue samples of the same document line leave the block together.

The physical rows are `ROW_GAP` scan lines apart, four by default. The row that scans a document line first therefore has to wait twice that many lines, the middle row waits once, and the last row is passed straight through. A static direction input chooses whether red or blue is treated as the first row. Two circular buffers hold the delayed rows, and a small serializer emits one RGB pixel per cycle with a valid flag and a line-start marker. The line length `LINE_PIX` is a parameter. It is set to the full sensor width of 5000 when the block is instantiated in the chip; the default is kept short.

Top module: `rgb_line_align`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid`, `out_line_start` and `primed` are 0.
- R2: A beat is stored and counted only when `in_valid` is 1 and `in_kind` is 2'b00 (active picture). Kinds 2'b01 (dummy), 2'b10 (shielded black) and 2'b11 (void) are dropped: they produce no output and do not advance the pixel column.
- R3: Each accepted pair yields two output pixels on consecutive cycles, the odd-stream pixel (0-based index 2k) first and the even-stream pixel (2k+1) second. The first of the two appears one clock edge after the edge that accepted the beat.
- R4: With `scan_reverse`=0, the red output comes from the input line 2*ROW_GAP lines earlier, green from ROW_GAP lines earlier, and blue from the current line.
- R5: With `scan_reverse`=1, the blue output comes from 2*ROW_GAP lines earlier, green from ROW_GAP lines earlier, and red from the current line.
- R6: `primed` rises after 2*ROW_GAP complete lines (LINE_PIX/2 accepted beats each) have been taken in, and stays high until reset. No pixel is output before that.
- R7: `out_line_start` is 1 only together with the odd pixel of pair 0 of a line, and only while `out_valid` is 1.
- R8: `out_valid` is 0 on every cycle that carries no pixel: between lines, during dropped beats and when idle. Each line yields exactly LINE_PIX output pixels.
- R9: Accepted beats must be at least two cycles apart. At exactly that spacing the pixels of a line come out with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_reverse | input | 1 | Static scan direction: 0 delays red most, 1 delays blue most |
| in_valid | input | 1 | Input beat strobe shared by all six streams |
| in_kind | input | 2 | Beat class: 00 active, 01 dummy, 10 shielded black, 11 void |
| red_odd_px | input | PIX_W | Red pixel 2k of the current pair |
| red_even_px | input | PIX_W | Red pixel 2k+1 of the current pair |
| grn_odd_px | input | PIX_W | Green pixel 2k |
| grn_even_px | input | PIX_W | Green pixel 2k+1 |
| blu_odd_px | input | PIX_W | Blue pixel 2k |
| blu_even_px | input | PIX_W | Blue pixel 2k+1 |
| out_valid | output | 1 | Aligned pixel present |
| out_line_start | output | 1 | First aligned pixel of a line |
| out_red | output | PIX_W | Aligned red sample |
| out_grn | output | PIX_W | Aligned green sample |
| out_blu | output | PIX_W | Aligned blue sample |
| primed | output | 1 | Longest delay has been filled |

## Verification
The bench tags every pixel with its colour, line and column, so a mistake in alignment shows up as the wrong line number in a colour field. A swapped direction multiplexer or a delay that is one line short would do exactly that. Dropped beats of every kind are placed in the middle of a line; a design that let them advance the column would move the line-start marker and shift every later pixel. The bench also sends the line that completes priming and looks for outputs issued one line too early. It checks the order and timing of each odd/even pair, and that no valid cycles leak into the idle gaps between lines.

// File: rtl/rla_pkg.sv
package rla_pkg;

  typedef enum logic [1:0] {
    KIND_ACTIVE = 2'b00,
    KIND_DUMMY  = 2'b01,
    KIND_SHIELD = 2'b10,
    KIND_VOID   = 2'b11
  } px_kind_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_EVEN = 1'b1
  } ser_phase_e;

  // Lane 0 holds the row delayed longest, lane 1 the middle row,
  // lane 2 the row passed through without storage.
  localparam int NUM_LANES = 3;

  function automatic int lane_lines(input int lane, input int gap);
    if (lane == 0) return 2 * gap;
    if (lane == 1) return gap;
    return 0;
  endfunction

endpackage

// File: rtl/rla_line_tracker.sv
module rla_line_tracker #(
  parameter int PAIRS       = 160,
  parameter int PRIME_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic pair_valid,
  output logic pair_first,
  output logic primed
);

  localparam int CW = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int LW = $clog2(PRIME_LINES + 1);

  logic [CW-1:0] col_q, col_d;
  logic [LW-1:0] lines_q, lines_d;
  logic          last_col, full;
  logic          pv_q, pf_q;

  // next state
  always_comb begin
    last_col = (col_q == CW'(PAIRS - 1));
    full     = (lines_q == LW'(PRIME_LINES));
    col_d    = col_q;
    lines_d  = lines_q;
    if (beat) begin
      col_d = last_col ? '0 : col_q + 1'b1;
      if (last_col && !full) lines_d = lines_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      lines_q <= '0;
      pv_q    <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      if (beat) begin
        col_q   <= col_d;
        lines_q <= lines_d;
      end
      pv_q <= beat && full;
      pf_q <= beat && (col_q == '0);
    end
  end

  assign pair_valid = pv_q;
  assign pair_first = pf_q;
  assign primed     = full;

endmodule

// File: rtl/rla_delay_line.sv
module rla_delay_line #(
  parameter int W     = 24,
  parameter int DEPTH = 640
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (DEPTH == 0) begin : g_direct
      logic [W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (push) q <= din;
      end
      assign dout = q;
    end else begin : g_ring
      localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] ptr_q, ptr_d;
      logic [W-1:0]  rd_q;

      always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr_q <= '0;
        else if (push) ptr_q <= ptr_d;
      end

      // read the oldest entry, then overwrite it with the newest
      always_ff @(posedge clk) begin
        if (push) begin
          rd_q         <= mem[ptr_q];
          mem[ptr_q]   <= din;
        end
      end

      assign dout = rd_q;
    end
  endgenerate

endmodule

// File: rtl/rla_pair_serializer.sv
module rla_pair_serializer
  import rla_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pair_valid,
  input  logic         pair_first,
  input  logic [W-1:0] odd_px,
  input  logic [W-1:0] even_px,
  output logic         out_valid,
  output logic         out_first,
  output logic [W-1:0] out_px
);

  ser_phase_e   phase_q, phase_d;
  logic         v_q, v_d, f_q, f_d;
  logic [W-1:0] px_q, px_d, hold_q, hold_d;
  logic         hold_en;

  // next state: an even pixel still owed always goes out first
  always_comb begin
    phase_d = PH_IDLE;
    v_d     = 1'b0;
    f_d     = 1'b0;
    px_d    = px_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (phase_q == PH_EVEN) begin
      v_d  = 1'b1;
      px_d = hold_q;
    end else if (pair_valid) begin
      v_d     = 1'b1;
      f_d     = pair_first;
      px_d    = odd_px;
      hold_d  = even_px;
      hold_en = 1'b1;
      phase_d = PH_EVEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      v_q     <= 1'b0;
      f_q     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      v_q     <= v_d;
      f_q     <= f_d;
    end
  end

  always_ff @(posedge clk) begin
    if (v_d)     px_q   <= px_d;
    if (hold_en) hold_q <= hold_d;
  end

  assign out_valid = v_q;
  assign out_first = f_q;
  assign out_px    = px_q;

endmodule

// File: rtl/rgb_line_align.sv
module rgb_line_align
  import rla_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int LINE_PIX = 320,
  parameter int ROW_GAP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_reverse,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic [PIX_W-1:0] red_odd_px,
  input  logic [PIX_W-1:0] red_even_px,
  input  logic [PIX_W-1:0] grn_odd_px,
  input  logic [PIX_W-1:0] grn_even_px,
  input  logic [PIX_W-1:0] blu_odd_px,
  input  logic [PIX_W-1:0] blu_even_px,
  output logic             out_valid,
  output logic             out_line_start,
  output logic [PIX_W-1:0] out_red,
  output logic [PIX_W-1:0] out_grn,
  output logic [PIX_W-1:0] out_blu,
  output logic             primed
);

  localparam int PAIRS       = LINE_PIX / 2;
  localparam int PRIME_LINES = 2 * ROW_GAP;
  localparam int LANE_W      = 2 * PIX_W;
  localparam int RGB_W       = 3 * PIX_W;

  logic              beat;
  logic [LANE_W-1:0] red_pair, grn_pair, blu_pair;
  logic [LANE_W-1:0] lane_din  [NUM_LANES];
  logic [LANE_W-1:0] lane_dout [NUM_LANES];
  logic [LANE_W-1:0] red_old, grn_old, blu_old;
  logic [RGB_W-1:0]  odd_rgb, even_rgb, rgb_out;
  logic              pair_valid, pair_first;

  assign beat     = in_valid && (in_kind == KIND_ACTIVE);
  assign red_pair = {red_even_px, red_odd_px};
  assign grn_pair = {grn_even_px, grn_odd_px};
  assign blu_pair = {blu_even_px, blu_odd_px};

  // route colours onto lanes by scan direction
  always_comb begin
    lane_din[0] = scan_reverse ? blu_pair : red_pair;
    lane_din[1] = grn_pair;
    lane_din[2] = scan_reverse ? red_pair : blu_pair;
  end

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      rla_delay_line #(
        .W     (LANE_W),
        .DEPTH (lane_lines(i, ROW_GAP) * PAIRS)
      ) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .push (beat),
        .din  (lane_din[i]),
        .dout (lane_dout[i])
      );
    end
  endgenerate

  always_comb begin
    red_old = scan_reverse ? lane_dout[2] : lane_dout[0];
    grn_old = lane_dout[1];
    blu_old = scan_reverse ? lane_dout[0] : lane_dout[2];
    odd_rgb  = {red_old[PIX_W-1:0],      grn_old[PIX_W-1:0],      blu_old[PIX_W-1:0]};
    even_rgb = {red_old[LANE_W-1:PIX_W], grn_old[LANE_W-1:PIX_W], blu_old[LANE_W-1:PIX_W]};
  end

  rla_line_tracker #(
    .PAIRS      (PAIRS),
    .PRIME_LINES(PRIME_LINES)
  ) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .pair_valid(pair_valid),
    .pair_first(pair_first),
    .primed    (primed)
  );

  rla_pair_serializer #(
    .W(RGB_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_valid(pair_valid),
    .pair_first(pair_first),
    .odd_px    (odd_rgb),
    .even_px   (even_rgb),
    .out_valid (out_valid),
    .out_first (out_line_start),
    .out_px    (rgb_out)
  );

  assign out_red = rgb_out[RGB_W-1:2*PIX_W];
  assign out_grn = rgb_out[2*PIX_W-1:PIX_W];
  assign out_blu = rgb_out[PIX_W-1:0];

endmodule

// File: rtl/rgb_line_align_chk.sv
module rgb_line_align_chk
  import rla_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] in_kind,
  input logic       out_valid,
  input logic       out_line_start,
  input logic       primed
);

  logic acc, a1, a2, a3;
  assign acc = in_valid && (in_kind == KIND_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= 1'b0;
      a2 <= 1'b0;
      a3 <= 1'b0;
    end else begin
      a1 <= acc;
      a2 <= a1;
      a3 <= a2;
    end
  end

  assert_beat_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !acc);

  assert_pair_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_line_start) |=> (out_valid && !out_line_start));

  assert_no_early_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> primed);

  assert_primed_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

  assert_start_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_line_start |-> out_valid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (a2 || a3));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !primed));

endmodule

bind rgb_line_align rgb_line_align_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_kind       (in_kind),
  .out_valid     (out_valid),
  .out_line_start(out_line_start),
  .primed        (primed)
);

// File: tb/test_rgb_line_align.sv
module test_rgb_line_align;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 12;
  localparam int LINE_PIX   = 8;
  localparam int PAIRS      = LINE_PIX / 2;
  localparam int GAP        = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             scan_reverse;
  logic             in_valid;
  logic [1:0]       in_kind;
  logic [PIX_W-1:0] r_o, r_e, g_o, g_e, b_o, b_e;
  logic             out_valid, out_line_start, primed;
  logic [PIX_W-1:0] out_red, out_grn, out_blu;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  int               cap_n = 0;
  logic [PIX_W-1:0] cap_r [64];
  logic [PIX_W-1:0] cap_g [64];
  logic [PIX_W-1:0] cap_b [64];
  logic             cap_s [64];
  int               cap_t [64];

  rgb_line_align #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .ROW_GAP(GAP)) i_rgb_line_align (
    .clk(clk), .rst_n(rst_n), .scan_reverse(scan_reverse),
    .in_valid(in_valid), .in_kind(in_kind),
    .red_odd_px(r_o), .red_even_px(r_e),
    .grn_odd_px(g_o), .grn_even_px(g_e),
    .blu_odd_px(b_o), .blu_even_px(b_e),
    .out_valid(out_valid), .out_line_start(out_line_start),
    .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
    .primed(primed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (cap_n < 64) begin
        cap_r[cap_n] = out_red;
        cap_g[cap_n] = out_grn;
        cap_b[cap_n] = out_blu;
        cap_s[cap_n] = out_line_start;
        cap_t[cap_n] = cyc;
      end
      cap_n++;
    end
  end

  // pixel tag: colour(2) line(6) column(4)
  function automatic logic [PIX_W-1:0] pv(input int c, input int l, input int p);
    return {2'(c), 6'(l), 4'(p)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit rev);
    rst_n = 1'b0; in_valid = 1'b0; in_kind = 2'b00; scan_reverse = rev;
    {r_o, r_e, g_o, g_e, b_o, b_e} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cap_n = 0;
  endtask

  task automatic send_beat(input logic [1:0] kind, input int l, input int k);
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind;
    r_o = pv(0, l, 2*k); r_e = pv(0, l, 2*k+1);
    g_o = pv(1, l, 2*k); g_e = pv(1, l, 2*k+1);
    b_o = pv(2, l, 2*k); b_e = pv(2, l, 2*k+1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_line(input int l, input bit junk);
    for (int k = 0; k < PAIRS; k++) begin
      send_beat(2'b00, l, k);
      if (junk && k == 1) begin
        send_beat(2'b01, 63, 7);
        send_beat(2'b10, 63, 7);
        send_beat(2'b11, 63, 7);
      end
    end
  endtask

  task automatic verify(input int base, input int nl, input bit rev, input int junk_line);
    int dr, db;
    dr = rev ? 0 : 2*GAP;
    db = rev ? 2*GAP : 0;
    check(cap_n == nl*LINE_PIX, "R8 pixel count", cap_n, nl*LINE_PIX);
    for (int i = 0; i < nl*LINE_PIX && i < 64 && i < cap_n; i++) begin
      int l, p;
      logic [3*PIX_W-1:0] a, e;
      l = base + i / LINE_PIX;
      p = i % LINE_PIX;
      a = {cap_r[i], cap_g[i], cap_b[i]};
      e = {pv(0, l-dr, p), pv(1, l-GAP, p), pv(2, l-db, p)};
      check(a == e, rev ? "R5 aligned rgb" : "R4 aligned rgb", a, e);
      check(cap_s[i] == (p == 0), "R7 line start", cap_s[i], p == 0);
      if (p % 2 == 1)
        check(cap_t[i] == cap_t[i-1] + 1, "R3 even follows odd", cap_t[i], cap_t[i-1] + 1);
      else if (p != 0 && l != junk_line)
        check(cap_t[i] == cap_t[i-1] + 1, "R9 gapless line", cap_t[i], cap_t[i-1] + 1);
    end
  endtask

  task automatic test_reset();
    do_reset(1'b0);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(out_line_start == 1'b0, "R1 out_line_start", out_line_start, 0);
    check(primed == 1'b0, "R1 primed", primed, 0);
  endtask

  task automatic test_priming();
    for (int l = 0; l < 2*GAP - 1; l++) send_line(l, l == 3);
    check(primed == 1'b0, "R6 not primed after 7 lines", primed, 0);
    send_line(2*GAP - 1, 1'b0);
    repeat (4) @(negedge clk);
    check(primed == 1'b1, "R6 primed after 8 lines", primed, 1);
    check(cap_n == 0, "R6 no output while priming", cap_n, 0);
  endtask

  task automatic test_forward();
    cap_n = 0;
    send_line(8, 1'b0);
    send_line(9, 1'b1);
    send_line(10, 1'b0);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R8 idle between lines", out_valid, 0);
    send_line(11, 1'b0);
    repeat (4) @(negedge clk);
    verify(8, 4, 1'b0, 9);
  endtask

  task automatic test_discard();
    cap_n = 0;
    send_beat(2'b01, 60, 1);
    send_beat(2'b10, 61, 2);
    send_beat(2'b11, 62, 3);
    repeat (4) @(negedge clk);
    check(cap_n == 0, "R2 dropped beats give no output", cap_n, 0);
    check(out_valid == 1'b0, "R2 out_valid after dropped beats", out_valid, 0);
    send_line(12, 1'b0);
    repeat (4) @(negedge clk);
    verify(12, 1, 1'b0, -1);
  endtask

  task automatic test_reverse();
    do_reset(1'b1);
    for (int l = 0; l < 2*GAP; l++) send_line(l, 1'b0);
    repeat (4) @(negedge clk);
    check(cap_n == 0, "R6 reverse priming quiet", cap_n, 0);
    send_line(8, 1'b0);
    send_line(9, 1'b1);
    repeat (4) @(negedge clk);
    verify(8, 2, 1'b1, 9);
  endtask

  initial begin
    test_reset();
    test_priming();
    test_forward();
    test_discard();
    test_reverse();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule